// File: doc/BRIEF.md
# Iterative Factorial Engine

The engine computes the factorial of an operand that software writes through a small register port, and keeps the product truncated to the data width (32 bits by default). A multiply runs once per clock, so a result takes a number of cycles that grows with the operand. Software either polls a busy flag or waits for a one-cycle completion pulse, which goes to a separate interrupt unit.

The operand/result register sits at offset 0x08 and the status register at offset 0x20. Status bit 0 is the busy flag and status bit 7 is the completion-interrupt enable. Software cannot write the busy flag. Reads are registered and return data one cycle after the read request.

Top module: `fact_engine`

## Requirements
- R1: After reset, the busy flag, the interrupt enable, the completion pulse and the 0x08 register all read as zero, and `rd_data` is zero.
- R2: A write to offset 0x08 while idle loads the operand and sets busy (status bit 0). While busy, a read of 0x08 returns that operand.
- R3: A write to offset 0x08 while busy is ignored. The operand, the running computation and the final result are not affected.
- R4: On completion, 0x08 holds N! modulo 2^32, where the product starts from 1. So 0 and 1 both give 1, 13 gives 1932053504 and 34 gives 0.
- R5: Busy clears exactly N+1 clock edges after the edge that accepted the operand N.
- R6: A write to offset 0x20 sets the interrupt enable when data bit 7 is 1 and clears it when bit 7 is 0. The busy flag ignores such writes.
- R7: `irq_pulse` is high for exactly one cycle: the first cycle in which busy reads low after a computation. It fires only if the enable was set before that clock edge. With the enable clear, no pulse occurs.
- R8: A read is registered. `rd_data` updates at the edge that samples `rd_en` and then holds. Offset 0x20 returns the enable at bit 7, busy at bit 0 and zeros elsewhere. Any unmapped offset returns all ones.
- R9: Writes to unmapped offsets change neither the 0x08 register nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | DATA_W | Registered read data, valid the cycle after `rd_en` |
| irq_pulse | output | 1 | One-cycle completion pulse to the interrupt unit |

## Verification
After the edge that loads operand N, the completion pulse is due N+1 edges later. A status read that polls every cycle first shows busy low on its (N+2)th sampling edge, because the read register adds one stage. The bench drives and samples on falling edges. It counts the elapsed edges from the accepting write and compares that count against N+1 for the pulse and N+2 for the polled busy bit, including the runs that start with an ignored write. Each result read is issued only after the pulse (or the busy bit) shows completion, and its value is taken one edge after the request.

// File: rtl/fact_pkg.sv
package fact_pkg;
  // Register offsets decoded by software; kept fixed.
  localparam logic [7:0] OFS_VALUE  = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h20;
  // Status bit positions.
  localparam int BUSY_BIT = 0;
  localparam int IEN_BIT  = 7;

  typedef enum logic {
    CORE_IDLE = 1'b0,
    CORE_RUN  = 1'b1
  } core_state_t;
endpackage

// File: rtl/fact_decode.sv
module fact_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              busy,
  output logic              load,
  output logic              status_wr
);
  import fact_pkg::*;

  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  always_comb begin
    load      = wr_en && (wr_addr == A_VALUE) && !busy;
    status_wr = wr_en && (wr_addr == A_STATUS);
  end
endmodule

// File: rtl/fact_core.sv
module fact_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] operand,
  output logic              busy,
  output logic              finish,
  output logic [DATA_W-1:0] value
);
  import fact_pkg::*;

  core_state_t       state_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CORE_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
      value_q <= '0;
    end else begin
      case (state_q)
        CORE_IDLE: begin
          if (load) begin
            cnt_q   <= operand;
            acc_q   <= DATA_W'(1);
            value_q <= operand;
            state_q <= CORE_RUN;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            value_q <= acc_q;
            state_q <= CORE_IDLE;
          end else begin
            acc_q <= acc_q * cnt_q;
            cnt_q <= cnt_q - DATA_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    busy   = (state_q == CORE_RUN);
    finish = (state_q == CORE_RUN) && (cnt_q == '0);
    value  = value_q;
  end
endmodule

// File: rtl/fact_ctrl.sv
module fact_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic status_wr,
  input  logic ien_data,
  input  logic finish,
  output logic ien,
  output logic irq
);
  logic ien_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (status_wr) ien_q <= ien_data;
      irq_q <= finish & ien_q;
    end
  end

  always_comb begin
    ien = ien_q;
    irq = irq_q;
  end
endmodule

// File: rtl/fact_readback.sv
module fact_readback #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] value,
  input  logic              busy,
  input  logic              ien,
  output logic [DATA_W-1:0] rd_data
);
  import fact_pkg::*;

  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    status_word           = '0;
    status_word[BUSY_BIT] = busy;
    status_word[IEN_BIT]  = ien;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      if (rd_addr == A_VALUE)       rd_q <= value;
      else if (rd_addr == A_STATUS) rd_q <= status_word;
      else                          rd_q <= '1;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse
);
  import fact_pkg::*;

  logic              load_w;
  logic              status_wr_w;
  logic              busy_w;
  logic              finish_w;
  logic              ien_w;
  logic [DATA_W-1:0] value_w;

  fact_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .busy      (busy_w),
    .load      (load_w),
    .status_wr (status_wr_w)
  );

  fact_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (load_w),
    .operand (wr_data),
    .busy    (busy_w),
    .finish  (finish_w),
    .value   (value_w)
  );

  fact_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .status_wr (status_wr_w),
    .ien_data  (wr_data[IEN_BIT]),
    .finish    (finish_w),
    .ien       (ien_w),
    .irq       (irq_pulse)
  );

  fact_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_readback (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .value   (value_w),
    .busy    (busy_w),
    .ien     (ien_w),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/fact_engine_chk.sv
module fact_engine_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              ien,
  input logic              irq,
  input logic [DATA_W-1:0] value
);
  import fact_pkg::*;

  localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFS_VALUE);

  // R2: an accepted operand write starts a computation
  a_r2_load_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_VALUE && !busy) |=> busy);

  // R3: the 0x08 register cannot change while a computation continues
  a_r3_value_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(value)));

  // R6: busy only rises from an operand write
  a_r6_busy_not_writable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && wr_addr == A_VALUE));

  // R7: pulse marks the first idle cycle
  a_r7_irq_on_clear: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));

  // R7: pulse is a single cycle
  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R7: pulse needs the enable
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien));
endmodule

bind fact_engine fact_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .busy    (busy_w),
  .ien     (ien_w),
  .irq     (irq_pulse),
  .value   (value_w)
);

// File: tb/test_fact_engine.sv
module test_fact_engine;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NVEC   = 8;
  localparam logic [31:0] VEC_N [NVEC] = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd5,
                                           32'd12, 32'd13, 32'd34};
  localparam logic [31:0] VEC_F [NVEC] = '{32'd1, 32'd1, 32'd2, 32'd6, 32'd120,
                                           32'd479001600, 32'd1932053504, 32'd0};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq_pulse;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fact_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fact_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  always @(negedge clk) if (!rst && irq_pulse) irq_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Each task starts and ends on a falling edge and spans one rising edge.
  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq_pulse}, 32'h0);
    reg_read(8'h20, d); chk("R1 status", d, 32'h0);
    reg_read(8'h08, d); chk("R1 value", d, 32'h0);

    // R8 unmapped read and hold
    reg_read(8'h44, d); chk("R8 unmapped", d, 32'hFFFF_FFFF);
    @(negedge clk); chk("R8 hold", rd_data, 32'hFFFF_FFFF);

    // R6 enable write, busy not writable
    reg_write(8'h20, 32'h81); reg_read(8'h20, d); chk("R6 set", d, 32'h80);
    reg_write(8'h20, 32'h01); reg_read(8'h20, d); chk("R6 clear", d, 32'h00);

    // R9 unmapped write
    reg_write(8'h04, 32'h55); reg_write(8'h0C, 32'h80);
    reg_read(8'h08, d); chk("R9 value", d, 32'h0);
    reg_read(8'h20, d); chk("R9 status", d, 32'h0);

    // R2/R3/R5/R7 with enable clear: operand 10, ignored write, polled busy
    base = irq_seen;
    reg_write(8'h08, 32'd10);
    reg_read(8'h08, d); chk("R2 operand", d, 32'd10);
    reg_read(8'h20, d); chk("R2 busy", d, 32'h01);
    reg_write(8'h08, 32'd3);
    k = 3;
    do begin reg_read(8'h20, d); k++; end while (d[0] && k < 100);
    chk("R5 polled latency", k, 32'd12);
    reg_read(8'h08, d); chk("R3 result", d, 32'd3628800);
    chk("R7 no pulse", irq_seen - base, 32'd0);

    // R4/R5/R7 vector table with enable set
    reg_write(8'h20, 32'h80);
    for (int i = 0; i < NVEC; i++) begin
      reg_write(8'h08, VEC_N[i]);
      k = 0;
      do begin @(negedge clk); k++; end while (!irq_pulse && k < 100);
      chk("R5 pulse latency", k, VEC_N[i] + 32'd1);
      @(negedge clk); chk("R7 pulse width", {31'b0, irq_pulse}, 32'h0);
      reg_read(8'h08, d); chk("R4 result", d, VEC_F[i]);
    end

    // R7 enable set during a run
    reg_write(8'h20, 32'h00);
    base = irq_seen;
    reg_write(8'h08, 32'd6);
    reg_write(8'h20, 32'h80);
    repeat (10) @(negedge clk);
    chk("R7 late enable", irq_seen - base, 32'd1);
    reg_read(8'h08, d); chk("R4 six", d, 32'd720);

    done = 1'b1;
    finish_run();
  end
endmodule